// File: doc/BRIEF.md
# Local Claim Sampler

This block sits in a processor-bus host bridge. For each address tenure it decides whether an external local slave takes the transaction or the bridge's own memory path serves it. When a tenure starts, a tenure-relative cycle counter begins to run. At a wait-state point set by software, the block reads the slave's claim line, but only if the feature is switched on.

A claim seen at that point has two results. The block gives one address-acknowledge pulse, and it grants the data bus to the local slave. The slave then supplies its own transfer acknowledges. The grant lasts until one of these happens:
- the slave's final beat,
- a transfer error,
- a retry from another bus master in the single clock that follows the programmed snoop wait-state count.

When there is no claim, or the feature is off, the block raises a one-clock internal-target select so the memory path takes over. The block never drives a retry of its own.

Top module: `local_claim_sampler`

## Requirements
- R1: While `claimEnable` is low at the sample edge, `claimIn` has no effect: the tenure is treated as unclaimed and `localGrant` does not rise.
- R2: The sample edge is the (`hitDelay`+1)-th rising edge after the edge that captured `tenureStart`; `claimIn` and `claimEnable` are read only at that edge.
- R3: A claimed tenure gives `addrAck` high for exactly the one clock after the sample edge.
- R4: A claimed tenure raises `localGrant` in the clock after the sample edge and holds it until a terminating event.
- R5: An unclaimed tenure gives `internalSel` high for exactly the one clock after the sample edge, with `addrAck` and `localGrant` low.
- R6: While granted, an edge that sees `slaveAck` and `slaveLast` both high drops `localGrant` after that edge; `slaveAck` alone keeps the grant.
- R7: While granted, an edge that sees `xferErr` high drops `localGrant` after that edge.
- R8: `extRetry` is honoured only at the (`snoopWait`+2)-th edge after the start edge. There it ends the tenure: the grant drops, and if that edge is at or before the sample edge, none of `addrAck`, `localGrant` or `internalSel` is raised. `extRetry` at any other edge has no effect.
- R9: `tenureStart` is ignored while a tenure is in progress.
- R10: After reset, `addrAck`, `localGrant` and `internalSel` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tenureStart | input | 1 | Start of an address tenure, one clock |
| claimIn | input | 1 | Claim line from the local slave |
| claimEnable | input | 1 | Feature enable; when low, claims are ignored |
| hitDelay | input | DELAY_W | Wait states before the claim sample |
| snoopWait | input | SNOOP_W | Snoop wait states; the retry window is the clock after |
| extRetry | input | 1 | Retry from another bus master |
| slaveAck | input | 1 | Data-beat acknowledge from the local slave |
| slaveLast | input | 1 | Marks the current beat as the final one |
| xferErr | input | 1 | Transfer error on the data tenure |
| addrAck | output | 1 | Address acknowledge for a claimed tenure |
| localGrant | output | 1 | Data-bus grant to the local slave |
| internalSel | output | 1 | Hand-off to the bridge's memory path |

## Verification
A faulty tenure-age count moves the sample edge or the retry window. Every later edge of `addrAck`, `localGrant` and `internalSel` then shifts by the same number of clocks, and this is visible at the first tenure whose wait-state setting exposes the error. A stuck or mis-sequenced state register shows up within one clock of the expected event: a grant that outlives the final beat or the error, a select pulse together with an acknowledge, or a tenure that restarts while busy. The per-clock reference comparison across every combination of `hitDelay` and `snoopWait` catches an off-by-one in either window on the clock where it occurs.

// File: rtl/lcs_pkg.sv
package lcs_pkg;
  typedef struct packed {
    logic clearAge;
    logic stepAge;
  } lcsStrobes_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WAIT  = 2'd1,
    ST_OWNED = 2'd2
  } lcsState_t;
endpackage

// File: rtl/lcs_datapath.sv
module lcs_datapath
  import lcs_pkg::*;
#(
  parameter int DELAY_W = 4,
  parameter int SNOOP_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  lcsStrobes_t        strb,
  input  logic [DELAY_W-1:0] hitDelay,
  input  logic [SNOOP_W-1:0] snoopWait,
  output logic               atSample,
  output logic               atRetryWin
);
  localparam int AW = ((DELAY_W > SNOOP_W) ? DELAY_W : SNOOP_W) + 1;
  localparam logic [AW-1:0] AGE_MAX = '1;

  logic [AW-1:0] age;
  logic [AW-1:0] sampleAt;
  logic [AW-1:0] retryAt;

  assign sampleAt = AW'(hitDelay);
  assign retryAt  = AW'(snoopWait) + AW'(1);

  always_ff @(posedge clk) begin
    if (!rst_n)
      age <= '0;
    else if (strb.clearAge)
      age <= '0;
    else if (strb.stepAge && age != AGE_MAX)
      age <= age + AW'(1);
  end

  assign atSample   = (age == sampleAt);
  assign atRetryWin = (age == retryAt);

  // R2: a fresh tenure restarts the age count from zero
  p_age_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    strb.clearAge |=> (age == '0));

  // R2: age never wraps back while stepping
  p_age_nowrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.stepAge && !strb.clearAge && age == AGE_MAX) |=> (age == AGE_MAX));
endmodule

// File: rtl/lcs_control.sv
module lcs_control
  import lcs_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tenureStart,
  input  logic        claimIn,
  input  logic        claimEnable,
  input  logic        extRetry,
  input  logic        slaveAck,
  input  logic        slaveLast,
  input  logic        xferErr,
  input  logic        atSample,
  input  logic        atRetryWin,
  output lcsStrobes_t strb,
  output logic        addrAck,
  output logic        localGrant,
  output logic        internalSel
);
  lcsState_t state, nextState;
  logic retryHit;
  logic takeClaim;
  logic passOn;
  logic endOwned;

  assign retryHit  = atRetryWin && extRetry;
  assign takeClaim = (state == ST_WAIT) && !retryHit && atSample && claimEnable && claimIn;
  assign passOn    = (state == ST_WAIT) && !retryHit && atSample && !(claimEnable && claimIn);
  assign endOwned  = retryHit || xferErr || (slaveAck && slaveLast);

  always_comb begin
    strb      = '0;
    nextState = state;
    unique case (state)
      ST_IDLE: begin
        if (tenureStart) begin
          strb.clearAge = 1'b1;
          nextState     = ST_WAIT;
        end
      end
      ST_WAIT: begin
        strb.stepAge = 1'b1;
        if (retryHit)       nextState = ST_IDLE;
        else if (takeClaim) nextState = ST_OWNED;
        else if (passOn)    nextState = ST_IDLE;
      end
      ST_OWNED: begin
        strb.stepAge = 1'b1;
        if (endOwned) nextState = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      addrAck     <= 1'b0;
      internalSel <= 1'b0;
    end else begin
      state       <= nextState;
      addrAck     <= takeClaim;
      internalSel <= passOn;
    end
  end

  assign localGrant = (state == ST_OWNED);

  // R1: a grant only ever follows an enabled, asserted claim
  p_claim_gated_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(localGrant) |-> $past(claimEnable && claimIn));

  // R3: the address acknowledge is a single clock and comes with the grant
  p_ack_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    addrAck |=> !addrAck);
  p_ack_with_grant_r3: assert property (@(posedge clk) disable iff (!rst_n)
    addrAck |-> localGrant);

  // R5: the hand-off pulse is single and exclusive with the grant
  p_sel_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    internalSel |-> (!localGrant && !addrAck));

  // R6: the final beat releases the bus on the next clock
  p_last_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (localGrant && slaveAck && slaveLast) |=> !localGrant);

  // R7: a transfer error releases the bus on the next clock
  p_err_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (localGrant && xferErr) |=> !localGrant);

  // R8: a retry in the window withdraws the grant
  p_retry_cancel_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (localGrant && atRetryWin && extRetry) |=> !localGrant);
endmodule

// File: rtl/local_claim_sampler.sv
module local_claim_sampler
  import lcs_pkg::*;
#(
  parameter int DELAY_W = 4,
  parameter int SNOOP_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tenureStart,
  input  logic               claimIn,
  input  logic               claimEnable,
  input  logic [DELAY_W-1:0] hitDelay,
  input  logic [SNOOP_W-1:0] snoopWait,
  input  logic               extRetry,
  input  logic               slaveAck,
  input  logic               slaveLast,
  input  logic               xferErr,
  output logic               addrAck,
  output logic               localGrant,
  output logic               internalSel
);
  lcsStrobes_t strb;
  logic atSample;
  logic atRetryWin;

  lcs_control ctrl_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .tenureStart (tenureStart),
    .claimIn     (claimIn),
    .claimEnable (claimEnable),
    .extRetry    (extRetry),
    .slaveAck    (slaveAck),
    .slaveLast   (slaveLast),
    .xferErr     (xferErr),
    .atSample    (atSample),
    .atRetryWin  (atRetryWin),
    .strb        (strb),
    .addrAck     (addrAck),
    .localGrant  (localGrant),
    .internalSel (internalSel)
  );

  lcs_datapath #(
    .DELAY_W (DELAY_W),
    .SNOOP_W (SNOOP_W)
  ) dp_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .strb       (strb),
    .hitDelay   (hitDelay),
    .snoopWait  (snoopWait),
    .atSample   (atSample),
    .atRetryWin (atRetryWin)
  );
endmodule

// File: tb/local_claim_sampler_tb_top.sv
`timescale 1ns/1ps
module local_claim_sampler_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tenureStart = 1'b0;
  logic claimIn = 1'b0;
  logic claimEnable = 1'b0;
  logic [3:0] hitDelay = '0;
  logic [3:0] snoopWait = '0;
  logic extRetry = 1'b0;
  logic slaveAck = 1'b0;
  logic slaveLast = 1'b0;
  logic xferErr = 1'b0;
  logic addrAck, localGrant, internalSel;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;
  bit checking = 1'b0;

  always #4 clk = ~clk;

  local_claim_sampler #(.DELAY_W(4), .SNOOP_W(4)) dut_i (
    .clk(clk), .rst_n(rst_n), .tenureStart(tenureStart), .claimIn(claimIn),
    .claimEnable(claimEnable), .hitDelay(hitDelay), .snoopWait(snoopWait),
    .extRetry(extRetry), .slaveAck(slaveAck), .slaveLast(slaveLast),
    .xferErr(xferErr), .addrAck(addrAck), .localGrant(localGrant),
    .internalSel(internalSel)
  );

  // Behavioural reference: edges counted since the start edge
  bit mBusy, mOwned, eAck, eSel;
  int mAge;

  always @(posedge clk) begin
    if (!rst_n) begin
      mBusy = 0; mOwned = 0; eAck = 0; eSel = 0; mAge = 0;
    end else begin
      eAck = 0; eSel = 0;
      if (!mBusy) begin
        if (tenureStart) begin mBusy = 1; mOwned = 0; mAge = 0; end
      end else begin
        mAge = mAge + 1;
        if (mAge == int'(snoopWait) + 2 && extRetry) begin
          mBusy = 0; mOwned = 0;                        // R8
        end else if (!mOwned && mAge == int'(hitDelay) + 1) begin
          if (claimEnable && claimIn) begin mOwned = 1; eAck = 1; end  // R2 R3 R4
          else begin eSel = 1; mBusy = 0; end                         // R1 R5
        end else if (mOwned && (xferErr || (slaveAck && slaveLast))) begin
          mOwned = 0; mBusy = 0;                                      // R6 R7
        end
      end
    end
  end

  task automatic check1(input string req, input logic act, input logic exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s at %0t: actual %0b expected %0b (hitDelay=%0d snoopWait=%0d)",
               req, $time, act, exp, hitDelay, snoopWait);
    end
  endtask

  always @(negedge clk) begin
    if (checking && rst_n) begin
      check1("R3 addrAck", addrAck, eAck);
      check1("R4 R6 R7 R8 R9 localGrant", localGrant, mOwned);
      check1("R1 R5 internalSel", internalSel, eSel);
    end
  end

  // mode 0: claimed, retry in window; 1: claimed, retries off-window;
  // 2: unclaimed; 3: disabled with claim high; 4: claimed, transfer error
  task automatic runTenure(input int hd, input int sw, input int mode);
    @(negedge clk);
    hitDelay = 4'(hd); snoopWait = 4'(sw);
    claimEnable = (mode != 3);
    tenureStart = 1'b1;
    claimIn = 1'b0; extRetry = 1'b0; slaveAck = 1'b0; slaveLast = 1'b0; xferErr = 1'b0;
    for (int j = 1; j <= 26; j++) begin
      @(negedge clk);
      tenureStart = (hd >= 1 && j == hd);                       // R9 ignored start
      case (mode)
        0, 1, 4: claimIn = (j == hd + 1);                       // R2 only the sample edge counts
        2:       claimIn = (j != hd + 1);
        default: claimIn = 1'b1;                                // R1
      endcase
      extRetry  = (mode == 0) ? (j == sw + 2) : (j != sw + 2);  // R8
      slaveAck  = 1'b1;
      slaveLast = (j == hd + 4);                                // R6
      xferErr   = (mode == 4) && (j == hd + 3);                 // R7
    end
    @(negedge clk);
    tenureStart = 1'b0; claimIn = 1'b0; extRetry = 1'b0;
    slaveAck = 1'b0; slaveLast = 1'b0; xferErr = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10: outputs quiet after reset
    check1("R10 addrAck", addrAck, 1'b0);
    check1("R10 localGrant", localGrant, 1'b0);
    check1("R10 internalSel", internalSel, 1'b0);
    checking = 1'b1;
    for (int hd = 0; hd < 16; hd++)
      for (int sw = 0; sw < 16; sw++)
        for (int mode = 0; mode < 5; mode++)
          runTenure(hd, sw, mode);
    checking = 1'b0;
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      compared++;
      mismatched++;
      $display("FAIL R10 watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule